// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block sits on the controller side of a 16-bit single-data-rate SDRAM with four banks. It accepts single-beat read and write requests on a valid/ready handshake and drives the memory's command pins: chip select, row strobe, column strobe, write enable, clock enable, bank select, address and the two byte masks. It keeps a record of the open row in every bank. A request that lands on the open row is served at once. A request to an idle bank first opens the row. A request that misses the open row first closes that bank and then opens the new row.

After reset the block runs the power-up sequence on its own, then raises `init_done`. From then on, an internal interval timer forces periodic refreshes, and these take priority over user traffic. Two request pins ask for low-power states through the clock enable. `pd_req` selects power-down, which keeps open rows open. `sr_req` selects self-refresh, which closes all banks first. Every command is registered, so a decision made in one cycle appears on the pins on the next clock edge.

Top module: `sdr_cmd_seq`

## Requirements
- R1: While reset is held, `sd_cke` is 0 and the command pins {cs_n,ras_n,cas_n,we_n} carry NOP = 0111. The other encodings are ACT 0011, RD 0101, WR 0100, PRE 0010, REF 0001 and MRS 0000.
- R2: After reset and at least INIT_CYCLES cycles of NOP with `sd_cke` high, the block issues these commands in order: PRE with A10=1, REF, REF, then MRS with A[6:4]=CAS_LAT, A[3:0]=0 and BA=0. `init_done` is high from the MRS onward.
- R3: ACT is issued only to a bank that is closed. It carries the bank on `sd_ba` and the row on `sd_addr`. A request to a closed bank causes exactly one ACT before its access.
- R4: RD and WR are issued only to an open bank. They carry the column on A[9:0] and the auto-precharge flag on A10, and drive `sd_dqm`={upper,lower} from `req_mask`.
- R5: A request whose row differs from the open row of its bank causes one PRE with A10=0 to that bank, then an ACT of the new row, then the access.
- R6: Minimum spacing is kept, counted in clock edges between commands. ACT to RD/WR is at least T_RCD. PRE to ACT on the same bank is at least T_RP. ACT to ACT on the same bank is at least T_RC. REF to ACT is at least T_RC. MRS to ACT is at least T_MRD.
- R7: A RD or WR with A10=1 leaves its bank closed. The next request to that bank opens it with ACT and no PRE.
- R8: A refresh falls due every REF_INTERVAL cycles and stays due until served. It is served ahead of waiting requests: a PRE with A10=1 comes first if any bank is open, then the REF. All banks are closed afterward.
- R9: With `pd_req` high and nothing else pending, `sd_cke` goes low and only NOP is driven. Open rows survive power-down, so a later hit needs no ACT.
- R10: Any command other than NOP is issued only when `sd_cke` was high on the previous edge as well.
- R11: With `sr_req` high, the block closes all banks and then issues REF with `sd_cke` low on the same edge. It holds `sd_cke` low until `sr_req` falls. After `sd_cke` rises, no command comes for at least T_RC cycles.
- R12: `req_ready` is high only in a cycle where the request is a row hit. The RD or WR for that request appears on the pins on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The request is taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_auto_pre | input | 1 | Close the bank after the access |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Target column |
| req_mask | input | 2 | Byte masks {upper,lower}, 1 = masked |
| pd_req | input | 1 | Request power-down |
| sr_req | input | 1 | Request self-refresh |
| init_done | output | 1 | Power-up sequence complete |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 13 | Multiplexed row/column address |
| sd_dqm | output | 2 | Byte masks {upper,lower} |

## Verification
The bench shortens INIT_CYCLES to 20 and REF_INTERVAL to 600 and keeps the default timings T_RCD=3, T_RP=3, T_RC=9, T_MRD=2 and CAS_LAT=3. With these values one run covers the whole power-up sequence and a forced refresh that arrives during a continuous stream of row hits. The same run also covers power-down and self-refresh, and all of it stays short of the next refresh. Because the timings are small and distinct, a swap of two timing values or an off-by-one in a spacing counter shows up as a command issued too early.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_PWR, ST_IPRE, ST_IREF1, ST_IREF2, ST_IMRS,
        ST_IDLE, ST_WAIT, ST_PD, ST_SR, ST_EXIT
    } seq_state_e;

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic due
);
    localparam int W = $clog2(INTERVAL + 1);
    localparam logic [W-1:0] LAST = W'(INTERVAL - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         due;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (ack) d.due = 1'b0;
        if (q.cnt == LAST) begin
            d.cnt = '0;
            d.due = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign due = q.due;

    // a pending refresh is never dropped without being served
    assert_due_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !ack) |=> due);

endmodule

// File: rtl/sdr_row_table.sv
module sdr_row_table #(
    parameter int BANKS = 4,
    parameter int ROW_W = 13
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [$clog2(BANKS)-1:0]        sel_bank,
    input  logic                            act_en,
    input  logic [ROW_W-1:0]                act_row,
    input  logic                            close_en,
    input  logic                            close_all,
    output logic [BANKS-1:0]                row_open,
    output logic [BANKS-1:0][ROW_W-1:0]     row_addr
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic             open_d, open_q;
        logic [ROW_W-1:0] row_d, row_q;

        always_comb begin
            open_d = open_q;
            row_d  = row_q;
            if (close_all || (close_en && sel_bank == b)) open_d = 1'b0;
            if (act_en && sel_bank == b) begin
                open_d = 1'b1;
                row_d  = act_row;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                row_q  <= '0;
            end else begin
                open_q <= open_d;
                row_q  <= row_d;
            end
        end

        assign row_open[b] = open_q;
        assign row_addr[b] = row_q;
    end

    assert_act_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |-> !row_open[sel_bank]);

    assert_close_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        close_en |-> row_open[sel_bank]);

endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
    import sdr_seq_pkg::*;
#(
    parameter int BANKS        = 4,
    parameter int ROW_W        = 13,
    parameter int COL_W        = 10,
    parameter int T_RCD        = 3,
    parameter int T_RP         = 3,
    parameter int T_RC         = 9,
    parameter int T_MRD        = 2,
    parameter int CAS_LAT      = 3,
    parameter int INIT_CYCLES  = 100,
    parameter int REF_INTERVAL = 780
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic                       req_auto_pre,
    input  logic [$clog2(BANKS)-1:0]   req_bank,
    input  logic [ROW_W-1:0]           req_row,
    input  logic [COL_W-1:0]           req_col,
    input  logic [1:0]                 req_mask,
    input  logic                       pd_req,
    input  logic                       sr_req,
    output logic                       init_done,
    output logic                       sd_cke,
    output logic                       sd_cs_n,
    output logic                       sd_ras_n,
    output logic                       sd_cas_n,
    output logic                       sd_we_n,
    output logic [$clog2(BANKS)-1:0]   sd_ba,
    output logic [ROW_W-1:0]           sd_addr,
    output logic [1:0]                 sd_dqm
);
    localparam int BA_W   = $clog2(BANKS);
    localparam int AP_BIT = 10;
    localparam int CNT_W  = $clog2(INIT_CYCLES + T_RC + CAS_LAT + T_RP + 2);

    typedef struct packed {
        seq_state_e        st;
        seq_state_e        ret;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rc;
        sdr_cmd_e          cmd;
        logic              cke;
        logic [BA_W-1:0]   ba;
        logic [ROW_W-1:0]  addr;
        logic [1:0]        dqm;
        logic              done;
    } seq_t;

    seq_t q, d;

    logic                        act_en, close_en, close_all, ref_ack, ref_due;
    logic [BANKS-1:0]            row_open;
    logic [BANKS-1:0][ROW_W-1:0] row_addr;
    logic                        any_open, hit;

    sdr_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .due(ref_due)
    );

    sdr_row_table #(.BANKS(BANKS), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .sel_bank(req_bank), .act_en(act_en),
        .act_row(req_row), .close_en(close_en), .close_all(close_all),
        .row_open(row_open), .row_addr(row_addr)
    );

    function automatic seq_t to_wait(seq_t s, int cycles, seq_state_e back);
        s.st  = ST_WAIT;
        s.cnt = CNT_W'(cycles - 1);
        s.ret = back;
        return s;
    endfunction

    assign any_open = |row_open;
    assign hit      = row_open[req_bank] && (row_addr[req_bank] == req_row);

    always_comb begin
        d         = q;
        d.cmd     = CMD_NOP;
        d.rc      = (q.rc != '0) ? q.rc - 1'b1 : q.rc;
        act_en    = 1'b0;
        close_en  = 1'b0;
        close_all = 1'b0;
        ref_ack   = 1'b0;
        req_ready = 1'b0;
        unique case (q.st)
            ST_PWR: begin
                d.cke = 1'b1;
                if (q.cnt == '0) d.st = ST_IPRE;
                else             d.cnt = q.cnt - 1'b1;
            end
            ST_IPRE: begin
                d.cmd  = CMD_PRE;
                d.addr = '0;
                d.addr[AP_BIT] = 1'b1;
                d = to_wait(d, T_RP, ST_IREF1);
            end
            ST_IREF1: begin
                d.cmd = CMD_REF;
                d = to_wait(d, T_RC, ST_IREF2);
            end
            ST_IREF2: begin
                d.cmd = CMD_REF;
                d = to_wait(d, T_RC, ST_IMRS);
            end
            ST_IMRS: begin
                d.cmd  = CMD_MRS;
                d.ba   = '0;
                d.addr = '0;
                d.addr[6:4] = 3'(CAS_LAT);
                d.done = 1'b1;
                d = to_wait(d, T_MRD, ST_IDLE);
            end
            ST_IDLE: begin
                if (ref_due || sr_req) begin
                    if (any_open) begin
                        d.cmd  = CMD_PRE;
                        d.addr = '0;
                        d.addr[AP_BIT] = 1'b1;
                        close_all = 1'b1;
                        d = to_wait(d, T_RP, ST_IDLE);
                    end else if (q.rc == '0) begin
                        d.cmd   = CMD_REF;
                        ref_ack = 1'b1;
                        if (ref_due) begin
                            d = to_wait(d, T_RC, ST_IDLE);
                        end else begin
                            d.cke = 1'b0;
                            d.st  = ST_SR;
                        end
                    end
                end else if (req_valid) begin
                    d.ba = req_bank;
                    if (hit) begin
                        req_ready = 1'b1;
                        d.cmd  = req_write ? CMD_WR : CMD_RD;
                        d.addr = '0;
                        d.addr[COL_W-1:0] = req_col;
                        d.addr[AP_BIT]    = req_auto_pre;
                        d.dqm  = req_mask;
                        close_en = req_auto_pre;
                        d = to_wait(d, (req_write ? 1 : CAS_LAT) + (req_auto_pre ? T_RP : 0), ST_IDLE);
                    end else if (row_open[req_bank]) begin
                        d.cmd  = CMD_PRE;
                        d.addr = '0;
                        close_en = 1'b1;
                        d = to_wait(d, T_RP, ST_IDLE);
                    end else if (q.rc == '0) begin
                        d.cmd  = CMD_ACT;
                        d.addr = req_row;
                        d.rc   = CNT_W'(T_RC - 1);
                        act_en = 1'b1;
                        d = to_wait(d, T_RCD, ST_IDLE);
                    end
                end else if (pd_req) begin
                    d.cke = 1'b0;
                    d.st  = ST_PD;
                end
            end
            ST_WAIT: begin
                if (q.cnt == '0) d.st = q.ret;
                else             d.cnt = q.cnt - 1'b1;
            end
            ST_PD: begin
                if (!pd_req || ref_due || sr_req) begin
                    d.cke = 1'b1;
                    d.st  = ST_EXIT;
                end
            end
            ST_SR: begin
                if (!sr_req) begin
                    d.cke = 1'b1;
                    d = to_wait(d, T_RC, ST_IDLE);
                end
            end
            ST_EXIT: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_PWR;
            q.ret  <= ST_IDLE;
            q.cnt  <= CNT_W'(INIT_CYCLES - 1);
            q.cmd  <= CMD_NOP;
            q.dqm  <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = q.cmd;
    assign sd_cke    = q.cke;
    assign sd_ba     = q.ba;
    assign sd_addr   = q.addr;
    assign sd_dqm    = q.dqm;
    assign init_done = q.done;

    assert_cke_lead_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd != CMD_NOP) |-> $past(sd_cke));

    assert_low_cke_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cke && q.cmd != CMD_NOP) |-> (q.cmd == CMD_REF && $past(sd_cke)));

    assert_ref_all_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_REF || q.cmd == CMD_MRS) |-> (row_open == '0));

    assert_ready_issues_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> (q.cmd == CMD_RD || q.cmd == CMD_WR));

endmodule

// File: tb/tb_sdr_cmd_seq.sv
module tb_sdr_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int T_RCD = 3, T_RP = 3, T_RC = 9, T_MRD = 2, CAS_LAT = 3;
    localparam int INIT_CYCLES = 20, REF_INTERVAL = 600;
    localparam int WATCHDOG = 20000;
    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

    // {wr, bank, row, col, auto_pre, mask, exp_act, exp_pre, pad}
    localparam int NVEC = 11;
    localparam logic [31:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 13'd5,    10'd10,   1'b0, 2'b00, 1'b1, 1'b0, 1'b0},
        {1'b1, 2'd0, 13'd5,    10'd11,   1'b0, 2'b01, 1'b0, 1'b0, 1'b0},
        {1'b0, 2'd0, 13'd7,    10'd3,    1'b0, 2'b10, 1'b1, 1'b1, 1'b0},
        {1'b1, 2'd1, 13'd100,  10'd1023, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0},
        {1'b0, 2'd1, 13'd100,  10'd0,    1'b0, 2'b00, 1'b1, 1'b0, 1'b0},
        {1'b0, 2'd3, 13'd8191, 10'd512,  1'b0, 2'b00, 1'b1, 1'b0, 1'b0},
        {1'b1, 2'd2, 13'd0,    10'd5,    1'b0, 2'b01, 1'b1, 1'b0, 1'b0},
        {1'b0, 2'd3, 13'd8191, 10'd513,  1'b1, 2'b00, 1'b0, 1'b0, 1'b0},
        {1'b1, 2'd3, 13'd8191, 10'd7,    1'b0, 2'b10, 1'b1, 1'b0, 1'b0},
        {1'b0, 2'd2, 13'd1,    10'd9,    1'b0, 2'b00, 1'b1, 1'b1, 1'b0},
        {1'b0, 2'd0, 13'd7,    10'd4,    1'b0, 2'b11, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, req_auto_pre = 0, pd_req = 0, sr_req = 0;
    logic [1:0] req_bank = 0, req_mask = 0;
    logic [12:0] req_row = 0;
    logic [9:0] req_col = 0;
    logic req_ready, init_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0] sd_ba, sd_dqm;
    logic [12:0] sd_addr;

    sdr_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD), .CAS_LAT(CAS_LAT),
                  .INIT_CYCLES(INIT_CYCLES), .REF_INTERVAL(REF_INTERVAL)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_auto_pre(req_auto_pre), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_mask(req_mask), .pd_req(pd_req),
        .sr_req(sr_req), .init_done(init_done), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0, cyc = 0, rel_cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // command log and pin-level bank model
    logic [3:0]  log_cmd  [1024];
    logic [1:0]  log_ba   [1024];
    logic [12:0] log_addr [1024];
    logic        log_cke  [1024];
    int          log_cyc  [1024];
    int          log_n = 0, ref_idx = -1, ref_seen = 0, cke_rise = -1000;
    bit [3:0]    mopen = 0;
    int          last_act [4] = '{-1000, -1000, -1000, -1000};
    int          last_pre [4] = '{-1000, -1000, -1000, -1000};
    int          last_ref = -1000, last_mrs = -1000;
    logic        prev_cke = 0;

    always @(negedge clk) begin
        logic [3:0] c;
        int b, pmax;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        b = int'(sd_ba);
        if (rst_n && c != C_NOP) begin
            check(prev_cke == 1'b1, "R10", "cke high on previous edge", prev_cke, 1);
            pmax = last_pre[0];
            for (int i = 1; i < 4; i++) if (last_pre[i] > pmax) pmax = last_pre[i];
            case (c)
                C_ACT: begin
                    check(!mopen[b], "R3", "act to closed bank", mopen[b], 0);
                    check(cyc - last_pre[b] >= T_RP, "R6", "pre to act", cyc - last_pre[b], T_RP);
                    check(cyc - last_act[b] >= T_RC, "R6", "act to act", cyc - last_act[b], T_RC);
                    check(cyc - last_ref >= T_RC, "R6", "ref to act", cyc - last_ref, T_RC);
                    check(cyc - last_mrs >= T_MRD, "R6", "mrs to act", cyc - last_mrs, T_MRD);
                    mopen[b] = 1'b1;
                    last_act[b] = cyc;
                end
                C_RD, C_WR: begin
                    check(mopen[b], "R4", "access to open bank", mopen[b], 1);
                    check(cyc - last_act[b] >= T_RCD, "R6", "act to access", cyc - last_act[b], T_RCD);
                    if (sd_addr[10]) begin
                        mopen[b] = 1'b0;
                        last_pre[b] = cyc + ((c == C_WR) ? 1 : CAS_LAT);
                    end
                end
                C_PRE: begin
                    if (sd_addr[10]) begin
                        mopen = 0;
                        for (int i = 0; i < 4; i++) last_pre[i] = cyc;
                    end else begin
                        mopen[b] = 1'b0;
                        last_pre[b] = cyc;
                    end
                end
                C_REF: begin
                    check(mopen == 0, "R8", "banks closed at refresh", mopen, 0);
                    check(cyc - pmax >= T_RP, "R6", "pre to ref", cyc - pmax, T_RP);
                    last_ref = cyc;
                    ref_idx = log_n;
                    ref_seen++;
                end
                C_MRS: begin
                    check(mopen == 0, "R2", "banks closed at mrs", mopen, 0);
                    last_mrs = cyc;
                end
                default: check(1'b0, "R1", "illegal command code", c, C_NOP);
            endcase
            if (log_n < 1024) begin
                log_cmd[log_n] = c; log_ba[log_n] = sd_ba; log_addr[log_n] = sd_addr;
                log_cke[log_n] = sd_cke; log_cyc[log_n] = cyc;
                log_n++;
            end
        end
        if (rst_n && sd_cke && !prev_cke) cke_rise = cyc;
        if (rst_n) prev_cke = sd_cke;
    end

    task automatic do_req(input bit wr, input logic [1:0] b, input logic [12:0] row,
                          input logic [9:0] col, input bit ap, input logic [1:0] m,
                          input int exp_act, input int exp_pre, input string tag);
        int start, n_act, n_pre, ai, pi;
        start = log_n;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_bank = b; req_row = row;
        req_col = col; req_auto_pre = ap; req_mask = m;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        #1;
        req_valid = 0;
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == (wr ? C_WR : C_RD), "R12",
              "access right after accept", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, wr ? C_WR : C_RD);
        check(sd_ba == b, "R4", "access bank", sd_ba, b);
        check(sd_addr[9:0] == col, "R4", "access column", sd_addr[9:0], col);
        check(sd_addr[10] == ap, "R4", "auto-precharge bit", sd_addr[10], ap);
        check(sd_dqm == m, "R4", "byte masks", sd_dqm, m);
        n_act = 0; n_pre = 0; ai = -1; pi = -1;
        for (int i = start; i < log_n - 1; i++) begin
            if (log_cmd[i] == C_ACT) begin n_act++; ai = i; end
            if (log_cmd[i] == C_PRE && !log_addr[i][10]) begin n_pre++; pi = i; end
        end
        if (exp_act >= 0) check(n_act == exp_act, tag, "activate count", n_act, exp_act);
        if (exp_pre >= 0) check(n_pre == exp_pre, tag, "single precharge count", n_pre, exp_pre);
        if (exp_act == 1 && ai >= 0) begin
            check(log_addr[ai] == row, "R3", "activate row", log_addr[ai], row);
            check(log_ba[ai] == b, "R3", "activate bank", log_ba[ai], b);
        end
        if (exp_pre == 1 && pi >= 0)
            check(log_ba[pi] == b, "R5", "precharge bank", log_ba[pi], b);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        int n0, guard, ri;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sd_cke == 1'b0, "R1", "cke in reset", sd_cke, 0);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "nop in reset",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        rst_n = 1;
        rel_cyc = cyc;

        // R2: power-up sequence
        guard = 0;
        while (!init_done && guard < 500) begin @(negedge clk); guard++; end
        repeat (T_MRD + 2) @(negedge clk);
        #1;
        check(log_n == 4, "R2", "init command count", log_n, 4);
        check(log_cmd[0] == C_PRE && log_addr[0][10], "R2", "first is precharge-all", log_cmd[0], C_PRE);
        check(log_cyc[0] - rel_cyc >= INIT_CYCLES, "R2", "power-up delay", log_cyc[0] - rel_cyc, INIT_CYCLES);
        check(log_cmd[1] == C_REF, "R2", "first refresh", log_cmd[1], C_REF);
        check(log_cmd[2] == C_REF, "R2", "second refresh", log_cmd[2], C_REF);
        check(log_cmd[3] == C_MRS, "R2", "mode register set", log_cmd[3], C_MRS);
        check(log_addr[3] == 13'(CAS_LAT << 4) && log_ba[3] == 0, "R2", "mode value",
              log_addr[3], CAS_LAT << 4);
        check(log_cke[0] && log_cke[3], "R2", "cke high during init", log_cke[0], 1);

        // table: hits, misses (R5), closed banks (R3), auto-precharge (R7)
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] e;
            e = VEC[v];
            do_req(e[31], e[30:29], e[28:16], e[15:6], e[5], e[4:3],
                   int'(e[2]), int'(e[1]), (v == 4 || v == 8) ? "R7" : (e[1] ? "R5" : "R3"));
        end

        // R8: refresh forced through a continuous hit stream
        guard = 0;
        while (ref_seen < 3 && guard < 300) begin
            do_req(1'b0, 2'd0, 13'd7, 10'(guard), 1'b0, 2'b00, -1, -1, "R8");
            guard++;
        end
        check(ref_seen == 3, "R8", "periodic refresh seen", ref_seen, 3);
        ri = ref_idx;
        check(log_cyc[ri] - rel_cyc >= REF_INTERVAL, "R8", "refresh not early",
              log_cyc[ri] - rel_cyc, REF_INTERVAL);
        check(log_cyc[ri] - rel_cyc <= REF_INTERVAL + 40, "R8", "refresh not starved",
              log_cyc[ri] - rel_cyc, REF_INTERVAL + 40);
        check(log_cmd[ri-1] == C_PRE && log_addr[ri-1][10], "R8", "precharge-all before refresh",
              log_cmd[ri-1], C_PRE);
        do_req(1'b0, 2'd2, 13'd1, 10'd9, 1'b0, 2'b00, 1, 0, "R8");

        // R9: power-down keeps rows open
        n0 = log_n;
        @(negedge clk); pd_req = 1;
        repeat (12) @(negedge clk);
        #1;
        check(sd_cke == 1'b0, "R9", "cke low in power-down", sd_cke, 0);
        check(log_n == n0, "R9", "no commands in power-down", log_n - n0, 0);
        pd_req = 0;
        do_req(1'b0, 2'd2, 13'd1, 10'd20, 1'b0, 2'b00, 0, 0, "R9");

        // R11: self-refresh
        n0 = log_n;
        @(negedge clk); sr_req = 1;
        guard = 0;
        while (ref_seen < 4 && guard < 100) begin @(negedge clk); guard++; end
        #1;
        ri = ref_idx;
        check(ref_seen == 4, "R11", "self-refresh entry", ref_seen, 4);
        check(log_cmd[ri-1] == C_PRE && log_addr[ri-1][10], "R11", "close all before entry",
              log_cmd[ri-1], C_PRE);
        check(log_cke[ri] == 1'b0, "R11", "cke low with refresh", log_cke[ri], 0);
        n0 = log_n;
        repeat (15) @(negedge clk);
        #1;
        check(sd_cke == 1'b0, "R11", "cke held low", sd_cke, 0);
        check(log_n == n0, "R11", "quiet in self-refresh", log_n - n0, 0);
        sr_req = 0;
        do_req(1'b0, 2'd2, 13'd1, 10'd21, 1'b0, 2'b01, 1, 0, "R11");
        check(log_cyc[n0] - cke_rise >= T_RC, "R11", "exit spacing", log_cyc[n0] - cke_rise, T_RC);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule